// File: doc/BRIEF.md
# Debug Access Port Register Bank

This block is an access port that hangs off a generic debug port. Every access arrives on a simple strobe bus that carries data, a two-bit word address, a read-not-write flag and a valid flag. It also receives the select word that the debug port has latched. The block responds only when the port-select byte of that word carries its own identifier. It then uses the bank nibble and the word address to pick one of three registers: a live status word, a control word, and a fixed identification word.

The control word drives two functions. Bit 0 starts a flash mass erase. If erase is enabled, the block raises a request level to the flash controller and holds it until that controller pulses completion, and hardware then clears the bit. If erase is not enabled, no request goes out and the bit stays set until system reset. Bit 1 drives a debug-disable output that overrides the core's own debug enable. A write to bit 1 is ignored while the device is secured, whereas bit 0 still works in that state.

Top module: `dbg_ap_regs`

## Requirements
- R1: An access reaches the registers only when sel_word[31:24] equals 0x01. For any other port-select value a read returns 0 and a write changes nothing.
- R2: In bank 0xF (sel_word[7:4]), acc_addr=3 reads 0x001C_0020. A write to that location has no effect.
- R3: In bank 0x0, acc_addr=0 reads the status word. Bit 0 is the live erase_en input, bit 1 is the live secured input, bit 2 is control bit 0 (erase pending), and all other bits are 0.
- R4: In bank 0x0, acc_addr=1 reads the control word. Bit 0 is the erase bit, bit 1 is the debug-disable bit, and all other bits are 0.
- R5: Writing 1 to control bit 0 while erase_en is high sets the bit. From the next cycle erase_req is high, and it stays high until the cycle that follows an erase_done pulse. In that cycle erase_req and the bit both read 0.
- R6: Writing 1 to control bit 0 while erase_en is low sets the bit but keeps erase_req low. The bit then stays set, even through erase_done pulses, until system reset.
- R7: An erase_done pulse with no pending request is ignored. Writing 0 to control bit 0 never clears it.
- R8: A write to control bit 1 while secured is low loads that bit, and dbg_disable follows it from the next cycle. While secured is high, bit 1 writes are ignored but bit 0 writes still take effect.
- R9: Unimplemented bank and address combinations read 0, and writes to them are ignored.
- R10: System reset (rst, synchronous, active high) clears both control bits, erase_req and rd_data.
- R11: rd_data is registered. It takes the read value in the cycle after a valid read and holds it until the next valid read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_rnw | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 2 | Word address within the bank |
| acc_wdata | input | 32 | Write data |
| sel_word | input | 32 | Latched select word (port select in [31:24], bank in [7:4]) |
| erase_en | input | 1 | Mass erase permitted |
| secured | input | 1 | Device secured |
| erase_done | input | 1 | Completion pulse from the flash controller |
| rd_data | output | 32 | Registered read data |
| erase_req | output | 1 | Mass erase request level |
| dbg_disable | output | 1 | Forces core debug off |

## Verification
The bench runs the erase handshake under three conditions: erase enabled, erase disabled, and the device secured. This separates the self-clearing request path from the stuck-bit path, and shows that security gates only bit 1. It also reads every register with the matching port select, with a foreign port select and with unused bank or address values, which separates correct decoding from aliasing. Stray completion pulses and writes of zero to the erase bit show that only the flash controller can clear the bit, and only while a request is pending.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int DW       = 32;
  localparam int AW       = 2;
  localparam int APSEL_HI = 31;
  localparam int APSEL_LO = 24;
  localparam int BANK_HI  = 7;
  localparam int BANK_LO  = 4;

  localparam logic [AW-1:0] ADDR_STAT = 2'd0;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd1;
  localparam logic [AW-1:0] ADDR_ID   = 2'd3;

  localparam int ST_EN  = 0;
  localparam int ST_SEC = 1;
  localparam int ST_BSY = 2;
  localparam int CT_ERS = 0;
  localparam int CT_DIS = 1;

  typedef struct packed {
    logic stat;
    logic ctrl;
    logic id;
  } hit_t;
endpackage

// File: rtl/dap_decode.sv
module dap_decode
  import dap_pkg::*;
#(
  parameter logic [7:0] AP_ID    = 8'h01,
  parameter logic [3:0] BANK_CS  = 4'h0,
  parameter logic [3:0] BANK_IDR = 4'hF
) (
  input  logic [DW-1:0] sel_word,
  input  logic [AW-1:0] addr,
  output hit_t          hit
);
  logic       ap_match;
  logic [3:0] bank;

  always_comb begin
    ap_match = (sel_word[APSEL_HI:APSEL_LO] == AP_ID);
    bank     = sel_word[BANK_HI:BANK_LO];
    hit.stat = ap_match && (bank == BANK_CS)  && (addr == ADDR_STAT);
    hit.ctrl = ap_match && (bank == BANK_CS)  && (addr == ADDR_CTRL);
    hit.id   = ap_match && (bank == BANK_IDR) && (addr == ADDR_ID);
  end
endmodule

// File: rtl/dap_ctrl.sv
module dap_ctrl
  import dap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          erase_en,
  input  logic          secured,
  input  logic          erase_done,
  output logic          ers_bit,
  output logic          dis_bit,
  output logic          erase_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ers_bit   <= 1'b0;
      dis_bit   <= 1'b0;
      erase_req <= 1'b0;
    end else begin
      if (erase_req && erase_done) begin
        ers_bit   <= 1'b0;
        erase_req <= 1'b0;
      end else if (wr_ctrl && wdata[CT_ERS] && !ers_bit) begin
        ers_bit   <= 1'b1;
        erase_req <= erase_en;
      end
      if (wr_ctrl && !secured) dis_bit <= wdata[CT_DIS];
    end
  end

  // R5: request implies pending bit
  a_r5_req_has_bit: assert property (@(posedge clk) disable iff (rst)
    erase_req |-> ers_bit);
  // R5: request held until done
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (erase_req && !erase_done) |=> erase_req);
  // R5: done retires request and bit
  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    (erase_req && erase_done) |=> (!erase_req && !ers_bit));
  // R6: a refused erase keeps its bit
  a_r6_stuck: assert property (@(posedge clk) disable iff (rst)
    (ers_bit && !erase_req) |=> (ers_bit && !erase_req));
  // R8: secured blocks debug-disable writes
  a_r8_secure_lock: assert property (@(posedge clk) disable iff (rst)
    secured |=> $stable(dis_bit));
endmodule

// File: rtl/dap_rdmux.sv
module dap_rdmux
  import dap_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h001C_0020
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  hit_t          hit,
  input  logic          erase_en,
  input  logic          secured,
  input  logic          ers_bit,
  input  logic          dis_bit,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] stat_w, ctrl_w, nxt;

  always_comb begin
    stat_w         = '0;
    stat_w[ST_EN]  = erase_en;
    stat_w[ST_SEC] = secured;
    stat_w[ST_BSY] = ers_bit;
    ctrl_w         = '0;
    ctrl_w[CT_ERS] = ers_bit;
    ctrl_w[CT_DIS] = dis_bit;
    unique case (1'b1)
      hit.stat: nxt = stat_w;
      hit.ctrl: nxt = ctrl_w;
      hit.id:   nxt = ID_VALUE;
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end

  // R2: identification read
  a_r2_id_value: assert property (@(posedge clk) disable iff (rst)
    (rd_en && hit.id) |=> (rd_data == ID_VALUE));
  // R11: idle cycles hold read data
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit.stat, hit.ctrl, hit.id}));
endmodule

// File: rtl/dbg_ap_regs.sv
module dbg_ap_regs
  import dap_pkg::*;
#(
  parameter logic [7:0]    AP_ID    = 8'h01,
  parameter logic [3:0]    BANK_CS  = 4'h0,
  parameter logic [3:0]    BANK_IDR = 4'hF,
  parameter logic [31:0]   ID_VALUE = 32'h001C_0020
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_valid,
  input  logic        acc_rnw,
  input  logic [1:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  input  logic [31:0] sel_word,
  input  logic        erase_en,
  input  logic        secured,
  input  logic        erase_done,
  output logic [31:0] rd_data,
  output logic        erase_req,
  output logic        dbg_disable
);
  hit_t hit;
  logic ers_bit, dis_bit, wr_ctrl, rd_en;

  assign wr_ctrl     = acc_valid && !acc_rnw && hit.ctrl;
  assign rd_en       = acc_valid && acc_rnw;
  assign dbg_disable = dis_bit;

  dap_decode #(.AP_ID(AP_ID), .BANK_CS(BANK_CS), .BANK_IDR(BANK_IDR)) u_dec (
    .sel_word(sel_word), .addr(acc_addr), .hit(hit)
  );

  dap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(acc_wdata),
    .erase_en(erase_en), .secured(secured), .erase_done(erase_done),
    .ers_bit(ers_bit), .dis_bit(dis_bit), .erase_req(erase_req)
  );

  dap_rdmux #(.ID_VALUE(ID_VALUE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .hit(hit),
    .erase_en(erase_en), .secured(secured),
    .ers_bit(ers_bit), .dis_bit(dis_bit), .rd_data(rd_data)
  );

  // R10: reset leaves outputs idle
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!erase_req && !dbg_disable && rd_data == '0));
endmodule

// File: tb/dbg_ap_regs_test.sv
module dbg_ap_regs_test;
  logic        clk = 0, rst = 1;
  logic        acc_valid = 0, acc_rnw = 0;
  logic [1:0]  acc_addr = 0;
  logic [31:0] acc_wdata = 0, sel_word = 0;
  logic        erase_en = 0, secured = 0, erase_done = 0;
  logic [31:0] rd_data;
  logic        erase_req, dbg_disable;
  int total = 0, bad = 0;

  localparam logic [31:0] SEL_CS  = 32'h0100_0000;
  localparam logic [31:0] SEL_ID  = 32'h0100_00F0;
  localparam logic [31:0] SEL_SYS = 32'h0000_00F0;

  always #2 clk = ~clk;

  dbg_ap_regs uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic [31:0] sel, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel_word = sel; acc_addr = a; acc_wdata = d; acc_rnw = 0; acc_valid = 1;
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic rd(input logic [31:0] sel, input logic [1:0] a, output logic [31:0] q);
    @(negedge clk);
    sel_word = sel; acc_addr = a; acc_rnw = 1; acc_valid = 1;
    @(negedge clk); acc_valid = 0; q = rd_data;
  endtask

  task automatic pulse_done();
    @(negedge clk); erase_done = 1;
    @(negedge clk); erase_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 rd_data", rd_data, 0);
    chk("R10 erase_req", {31'b0, erase_req}, 0);
    chk("R10 dbg_disable", {31'b0, dbg_disable}, 0);
  endtask

  task automatic t_id();
    logic [31:0] q;
    rd(SEL_ID, 2'd3, q);
    chk("R2 id read", q, 32'h001C_0020);
    wr(SEL_ID, 2'd3, 32'hFFFF_FFFF);
    rd(SEL_ID, 2'd3, q);
    chk("R2 id read-only", q, 32'h001C_0020);
    repeat (2) @(negedge clk);
    chk("R11 hold", rd_data, 32'h001C_0020);
    rd(SEL_SYS, 2'd3, q);
    chk("R1 foreign apsel read", q, 0);
    rd(SEL_CS, 2'd2, q);
    chk("R9 unused addr", q, 0);
    rd(SEL_ID, 2'd0, q);
    chk("R9 unused idr-bank addr", q, 0);
  endtask

  task automatic t_status();
    logic [31:0] q;
    erase_en = 1; secured = 0;
    rd(SEL_CS, 2'd0, q);
    chk("R3 status en", q, 32'h1);
    erase_en = 0; secured = 1;
    rd(SEL_CS, 2'd0, q);
    chk("R3 status sec", q, 32'h2);
    secured = 0;
  endtask

  task automatic t_foreign_write();
    logic [31:0] q;
    wr(SEL_SYS & 32'hFF00_0000, 2'd1, 32'h3);
    chk("R1 foreign write dis", {31'b0, dbg_disable}, 0);
    chk("R1 foreign write req", {31'b0, erase_req}, 0);
    wr(32'h0100_0020, 2'd1, 32'h2);
    chk("R9 wrong bank write", {31'b0, dbg_disable}, 0);
    rd(SEL_CS, 2'd1, q);
    chk("R4 ctrl idle", q, 0);
  endtask

  task automatic t_erase_ok();
    logic [31:0] q;
    do_reset(); erase_en = 1;
    pulse_done();
    chk("R7 stray done", {31'b0, erase_req}, 0);
    wr(SEL_CS, 2'd1, 32'h1);
    chk("R5 req raised", {31'b0, erase_req}, 1);
    wr(SEL_CS, 2'd1, 32'h0);
    rd(SEL_CS, 2'd1, q);
    chk("R7 zero write keeps bit", q, 32'h1);
    rd(SEL_CS, 2'd0, q);
    chk("R3 status busy", q, 32'h5);
    repeat (3) @(negedge clk);
    chk("R5 req held", {31'b0, erase_req}, 1);
    pulse_done();
    chk("R5 req dropped", {31'b0, erase_req}, 0);
    rd(SEL_CS, 2'd1, q);
    chk("R5 bit cleared", q, 0);
  endtask

  task automatic t_erase_blocked();
    logic [31:0] q;
    do_reset(); erase_en = 0;
    wr(SEL_CS, 2'd1, 32'h1);
    chk("R6 no req", {31'b0, erase_req}, 0);
    pulse_done();
    rd(SEL_CS, 2'd1, q);
    chk("R6 bit stuck", q, 32'h1);
    chk("R6 still no req", {31'b0, erase_req}, 0);
    do_reset();
    rd(SEL_CS, 2'd1, q);
    chk("R10 reset clears bit", q, 0);
  endtask

  task automatic t_debug();
    logic [31:0] q;
    do_reset(); secured = 0;
    wr(SEL_CS, 2'd1, 32'h2);
    chk("R8 disable set", {31'b0, dbg_disable}, 1);
    rd(SEL_CS, 2'd1, q);
    chk("R4 ctrl dis", q, 32'h2);
    wr(SEL_CS, 2'd1, 32'h0);
    chk("R8 disable clr", {31'b0, dbg_disable}, 0);
    secured = 1; erase_en = 1;
    wr(SEL_CS, 2'd1, 32'h3);
    chk("R8 secured ignores bit1", {31'b0, dbg_disable}, 0);
    chk("R8 secured erase works", {31'b0, erase_req}, 1);
    pulse_done(); secured = 0;
  endtask

  initial begin
    fork
      begin
        t_reset(); t_id(); t_status(); t_foreign_write();
        t_erase_ok(); t_erase_blocked(); t_debug();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule